// File: doc/BRIEF.md
# Seven-Entry LIFO Stack with Flags

This block is a synchronous last-in-first-out store for 8-bit words. It keeps up to seven words in an eight-slot buffer and addresses that buffer with a 3-bit pointer. The pointer always names the slot that the next pushed word will fill. The register outputs update on the rising edge of `clk`. There is no reset pin. The registers power up in the cleared state, and the synchronous `clear` input returns the block to that state at any time.

The producer side uses the `push` strobe, and `full` acts as its back-pressure. A push is accepted only in a cycle where `full` is low. Otherwise the word is refused, and the producer must hold it and try again. The consumer side works the same way with `pop` and `empty`. The newest entry is always visible on `data_out` without a pop. While the stack is empty, `data_out` reads zero. Overflow and underflow are blocked silently, with no error signal. The pointer is brought out on `sp` for observation.

Top module: `lifo7_stack`

## Requirements
- R1: At power-up, `sp` is 0, `empty` is 1, `full` is 0 and `data_out` is 8'h00.
- R2: A push with `full` low writes `data_in` into slot `sp` at the rising edge and increments `sp`. After that edge, `data_out` shows the pushed word.
- R3: A push while `full` is 1 has no effect. `sp` stays at 7 and `data_out` is unchanged.
- R4: A pop with `empty` low removes the newest entry at the rising edge and decrements `sp`. After that edge, `data_out` shows the entry below it, or 8'h00 if none remains.
- R5: A pop while `empty` is 1 has no effect. `sp` stays at 0.
- R6: Whenever `empty` is 1, `data_out` is 8'h00. Otherwise `data_out` is the word in slot `sp`-1.
- R7: `clear` high at a rising edge zeroes every buffer slot and sets `sp` to 0, `empty` to 1 and `full` to 0. It takes priority over `push` and `pop` in the same cycle.
- R8: `full` and `empty` are registered. `full` is 1 exactly when `sp` is 7, and `empty` is 1 exactly when `sp` is 0.
- R9: When push and pop are both high and neither is blocked, the newest entry is replaced by `data_in` and `sp` keeps its value.
- R10: When push and pop are both high and only one is allowed by the flags, only that one takes effect. On an empty stack the push proceeds. On a full stack the pop proceeds.
- R11: Words leave the stack in the reverse of their push order, across all seven entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clear | input | 1 | Synchronous clear, active high |
| push | input | 1 | Push strobe, active high |
| pop | input | 1 | Pop strobe, active high |
| data_in | input | 8 | Word to push |
| data_out | output | 8 | Newest stored word, or zero while empty |
| full | output | 1 | Registered flag: seven entries held |
| empty | output | 1 | Registered flag: no entries held |
| sp | output | 3 | Stack pointer, the next free slot |

## Verification
The pointer, the flags and the top-of-stack output are all visible at the ports. A pointer that drifts by one therefore shows up on `sp` and `data_out` in the very cycle after the faulty edge. A flag that disagrees with the pointer shows up in that same cycle. A wrong value written into a lower slot does not appear until that slot becomes the top, which is the pop that uncovers it. For that reason the bench pushes seven distinct words and pops all of them, comparing every step against a queue model. It also drives the combined push-and-pop cases at both the full boundary and the empty boundary, because those are the cases where one strobe must be masked and the other must not.

// File: rtl/lifo7_pkg.sv
package lifo7_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_SWAP = 2'b11
  } stk_op_e;
endpackage

// File: rtl/lifo7_ctrl.sv
module lifo7_ctrl
  import lifo7_pkg::*;
#(
  parameter int SLOTS = 8,
  localparam int PTR_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] sp,
  output logic             full,
  output logic             empty,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_idx
);
  localparam logic [PTR_W-1:0] TOP_PTR = PTR_W'(SLOTS - 1);

  logic [PTR_W-1:0] sp_q = '0;
  logic             full_q = 1'b0;
  logic             empty_q = 1'b1;
  logic [PTR_W-1:0] sp_d;
  stk_op_e          op;

  // Mask each strobe with the flag that blocks it.
  always_comb begin
    op = stk_op_e'({pop & ~empty_q, push & ~full_q});
  end

  always_comb begin
    unique case (op)
      OP_PUSH: sp_d = sp_q + PTR_W'(1);
      OP_POP:  sp_d = sp_q - PTR_W'(1);
      default: sp_d = sp_q;
    endcase
    if (clear) sp_d = '0;
  end

  always_comb begin
    wr_en  = ~clear & ((op == OP_PUSH) | (op == OP_SWAP));
    wr_idx = (op == OP_SWAP) ? sp_q - PTR_W'(1) : sp_q;
  end

  always_ff @(posedge clk) begin
    sp_q    <= sp_d;
    full_q  <= (sp_d == TOP_PTR);
    empty_q <= (sp_d == '0);
  end

  assign sp    = sp_q;
  assign full  = full_q;
  assign empty = empty_q;
endmodule

// File: rtl/lifo7_store.sv
module lifo7_store #(
  parameter int DATA_W = 8,
  parameter int SLOTS  = 8,
  localparam int PTR_W = $clog2(SLOTS)
) (
  input  logic                          clk,
  input  logic                          clear,
  input  logic                          wr_en,
  input  logic [PTR_W-1:0]              wr_idx,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [SLOTS-1:0][DATA_W-1:0]  slots
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [DATA_W-1:0] word_q = '0;
    always_ff @(posedge clk) begin
      if (clear)
        word_q <= '0;
      else if (wr_en && (wr_idx == PTR_W'(i)))
        word_q <= wr_data;
    end
    assign slots[i] = word_q;
  end
endmodule

// File: rtl/lifo7_tap.sv
module lifo7_tap #(
  parameter int DATA_W = 8,
  parameter int SLOTS  = 8,
  localparam int PTR_W = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0][DATA_W-1:0] slots,
  input  logic [PTR_W-1:0]             sp,
  input  logic                         empty,
  output logic [DATA_W-1:0]            top
);
  logic [PTR_W-1:0] rd_idx;

  always_comb begin
    rd_idx = sp - PTR_W'(1);
    top    = empty ? '0 : slots[rd_idx];
  end
endmodule

// File: rtl/lifo7_stack.sv
module lifo7_stack #(
  parameter int DATA_W = 8,
  parameter int SLOTS  = 8,
  localparam int PTR_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              clear,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              full,
  output logic              empty,
  output logic [PTR_W-1:0]  sp
);
  logic                         wr_en;
  logic [PTR_W-1:0]             wr_idx;
  logic [SLOTS-1:0][DATA_W-1:0] slots;

  lifo7_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk(clk), .clear(clear), .push(push), .pop(pop),
    .sp(sp), .full(full), .empty(empty),
    .wr_en(wr_en), .wr_idx(wr_idx)
  );

  lifo7_store #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_store (
    .clk(clk), .clear(clear), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(data_in), .slots(slots)
  );

  lifo7_tap #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_tap (
    .slots(slots), .sp(sp), .empty(empty), .top(data_out)
  );
endmodule

// File: rtl/lifo7_checker.sv
module lifo7_checker #(
  parameter int DATA_W = 8,
  parameter int SLOTS  = 8,
  localparam int PTR_W = $clog2(SLOTS)
) (
  input logic              clk,
  input logic              clear,
  input logic              push,
  input logic              pop,
  input logic [DATA_W-1:0] data_in,
  input logic [DATA_W-1:0] data_out,
  input logic              full,
  input logic              empty,
  input logic [PTR_W-1:0]  sp
);
  localparam logic [PTR_W-1:0] TOP_PTR = PTR_W'(SLOTS - 1);

  logic armed_q = 1'b0;
  always_ff @(posedge clk) armed_q <= 1'b1;

  assert_flags_match_R8: assert property (@(posedge clk) disable iff (!armed_q)
    (full == (sp == TOP_PTR)) && (empty == (sp == '0)));

  assert_empty_zero_R6: assert property (@(posedge clk) disable iff (!armed_q)
    empty |-> (data_out == '0));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!armed_q)
    (full && push && !pop && !clear) |=> (sp == TOP_PTR) && $stable(data_out));

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!armed_q)
    (empty && pop && !push && !clear) |=> (sp == '0) && empty);

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!armed_q)
    clear |=> (sp == '0) && empty && !full);

  assert_push_moves_R2: assert property (@(posedge clk) disable iff (!armed_q)
    (push && !pop && !full && !clear) |=>
      (sp == $past(sp) + PTR_W'(1)) && (data_out == $past(data_in)));

  assert_pop_moves_R4: assert property (@(posedge clk) disable iff (!armed_q)
    (pop && !push && !empty && !clear) |=> (sp == $past(sp) - PTR_W'(1)));

  assert_swap_top_R9: assert property (@(posedge clk) disable iff (!armed_q)
    (push && pop && !empty && !full && !clear) |=>
      $stable(sp) && (data_out == $past(data_in)));
endmodule

bind lifo7_stack lifo7_checker #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_checker (
  .clk(clk), .clear(clear), .push(push), .pop(pop), .data_in(data_in),
  .data_out(data_out), .full(full), .empty(empty), .sp(sp)
);

// File: tb/lifo7_stack_bench.sv
module lifo7_stack_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CAP = 7;

  logic       clk = 1'b0;
  logic       clear = 1'b0;
  logic       push = 1'b0;
  logic       pop = 1'b0;
  logic [7:0] data_in = '0;
  logic [7:0] data_out;
  logic       full;
  logic       empty;
  logic [2:0] sp;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] model[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lifo7_stack u_lifo7_stack (
    .clk(clk), .clear(clear), .push(push), .pop(pop), .data_in(data_in),
    .data_out(data_out), .full(full), .empty(empty), .sp(sp)
  );

  // Monitor side: compare the port state with the model.
  task automatic check(string tag);
    logic [7:0] exp_out;
    logic [2:0] exp_sp;
    exp_sp  = 3'(model.size());
    exp_out = (model.size() == 0) ? 8'h00 : model[$];
    tests++;
    if (data_out !== exp_out || sp !== exp_sp ||
        full !== (model.size() == CAP) || empty !== (model.size() == 0)) begin
      fails++;
      $display("FAIL %s: out=%h sp=%0d full=%b empty=%b, expected out=%h sp=%0d full=%b empty=%b",
               tag, data_out, sp, full, empty, exp_out, exp_sp,
               model.size() == CAP, model.size() == 0);
    end
  endtask

  // Driver side: apply one cycle of stimulus, update the expected queue.
  task automatic step(bit c, bit pu, bit po, logic [7:0] d, string tag);
    bit can_push;
    bit can_pop;
    clear = c; push = pu; pop = po; data_in = d;
    can_push = pu && (model.size() < CAP);
    can_pop  = po && (model.size() > 0);
    @(negedge clk);
    if (c) model.delete();
    else if (can_push && can_pop) model[$] = d;
    else if (can_push) model.push_back(d);
    else if (can_pop) void'(model.pop_back());
    clear = 0; push = 0; pop = 0;
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R1 power-up");
    step(0, 0, 1, 8'h00, "R5 pop on empty");
    for (int i = 0; i < CAP; i++) step(0, 1, 0, 8'h11 * (i + 1), "R2 push");
    step(0, 1, 0, 8'hEE, "R3 push on full");
    step(0, 1, 1, 8'hDD, "R10 push+pop on full");
    step(0, 1, 0, 8'h77, "R8 refill to full");
    step(0, 0, 1, 8'h00, "R4 pop from full");
    step(0, 1, 1, 8'hA5, "R9 swap top");
    step(0, 1, 1, 8'h5A, "R9 second swap");
    for (int i = 0; i < 6; i++) step(0, 0, 1, 8'h00, "R11 drain order");
    step(0, 0, 1, 8'h00, "R6 empty reads zero");
    step(0, 1, 1, 8'h3C, "R10 push+pop on empty");
    step(0, 1, 0, 8'h4B, "R2 push second");
    step(1, 1, 1, 8'h99, "R7 clear beats push and pop");
    step(0, 0, 1, 8'h00, "R7 pop after clear");
    step(0, 1, 0, 8'hC3, "R7 push after clear");
    step(1, 0, 0, 8'h00, "R7 plain clear");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule